// File: doc/BRIEF.md
# Deep Sleep Entry and Wakeup Sequencer

This block puts a system into a low-power state and brings it back out. A general-purpose input pin drives the sequence. Software first arms the block through a single 32-bit configuration register. A falling edge on the pin then drops the system clock enable. A later rising edge starts a programmable settle wait so that the oscillator can stabilise. When the wait ends, the clock enable is raised again and a sticky wakeup-done flag is set. Software polls this flag before it restarts memory and other modules. The flag clears only when software writes the arm bit back to zero.

The same register also holds an override for the USB VBUS drive output. When the override is on, a software-chosen level replaces the USB controller's request. The sequencer and its settle counter run on a free-running oscillator clock that is never gated. The pin passes through a two-flop synchroniser, and the block acts on the synchronised edges.

Top module: `deep_sleep_ctrl`

## Requirements
- R1: After reset the register reads 0x0000_1762: arm bit 31 = 0, settle field bits 15:4 = 0x176, VBUS override bit 1 = 1, VBUS force bit 2 = 0. The clock enable is 1.
- R2: While the arm bit is 0, pin edges are ignored and the clock enable stays 1.
- R3: While armed in normal operation, a falling pin edge drops the clock enable at the third clock edge after the pin changes. The done flag, bit 30, reads 0 while asleep.
- R4: In sleep, a rising pin edge raises the clock enable at clock edge 3 + 16·D after the pin change, where D is the settle field. Before that edge the clock enable stays 0.
- R5: With D = 0, the clock enable returns at the third clock edge after the pin rises.
- R6: A falling pin edge during the settle wait aborts the wakeup and returns to sleep. The next rising edge restarts the full 16·D wait.
- R7: Once awake, bit 30 reads 1 and stays 1 while the arm bit is 1, and pin edges in this state have no effect.
- R8: Writing the arm bit to 0 while awake returns the block to normal operation. Bit 30 reads 0 from the second clock edge, counting the write edge.
- R9: When bit 1 is 1, the VBUS drive output equals bit 2. When bit 1 is 0, it follows the USB request input. The path is combinational.
- R10: Bits 29:16, 3 and 0 always read 0. Bit 30 cannot be written.
- R11: The settle field, bits 15:4, and bits 31, 2 and 1 read back the last value written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| wake_pin | input | 1 | Asynchronous sleep/wake trigger pin |
| usb_vbus_req | input | 1 | VBUS drive request from USB controller |
| usb_vbus_drv | output | 1 | VBUS drive output |
| sys_clk_en | output | 1 | System clock enable |

## Verification
Register writes show on the read port at the negedge after the write edge. The VBUS output is checked 1 ns after its inputs change. A pin change reaches the state machine three edges later: two synchroniser flops, then the state register. The clock enable is therefore sampled at the negedge after edge 2 and again after edge 3 for sleep entry. For wakeup it is sampled after edges 2 + 16·D and 3 + 16·D, so that each check falls on the exact edge. The done flag is checked one edge after the arm-clearing write lands. Randomised settle values and VBUS settings reuse the same edge formulas, and directed cases cover D = 0, an aborted wait, and ignored pin edges.

// File: rtl/dsc_pkg.sv
// Shared types and register bit positions for the deep sleep sequencer.
// Assumes a single 32-bit configuration word with the settle field at 15:4.
package dsc_pkg;
    typedef enum logic [1:0] {
        ST_RUN       = 2'd0,
        ST_SLEEP     = 2'd1,
        ST_WAKE_WAIT = 2'd2,
        ST_AWAKE     = 2'd3
    } dsc_state_e;

    localparam int unsigned BIT_ARM    = 31;
    localparam int unsigned BIT_DONE   = 30;
    localparam int unsigned BIT_VFORCE = 2;
    localparam int unsigned BIT_VOVR   = 1;
    localparam int unsigned DLY_LSB    = 4;
endpackage

// File: rtl/dsc_pin_sync.sv
// Multi-flop synchroniser for the trigger pin with edge detection.
// Assumes the pin idles high (awake); all flops reset to 1 so no
// spurious edge appears at reset release.
module dsc_pin_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async,
    output logic pin_rise,
    output logic pin_fall
);
    logic [STAGES:0] shreg;

    // Shift the pin through the synchroniser plus one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) shreg <= '1;
        else        shreg <= {shreg[STAGES-1:0], pin_async};
    end

    // Edges compare the synchronised level with its previous value.
    always_comb begin
        pin_rise = shreg[STAGES-1] & ~shreg[STAGES];
        pin_fall = ~shreg[STAGES-1] & shreg[STAGES];
    end
endmodule

// File: rtl/dsc_cfg_regs.sv
// Configuration register: arm bit, settle field, VBUS override and force.
// Assumes a write strobe that updates all writable fields at once;
// the done flag is supplied by the sequencer and is read only.
module dsc_cfg_regs
    import dsc_pkg::*;
#(
    parameter int unsigned DLY_W   = 12,
    parameter int unsigned DLY_RST = 'h176
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [31:0]      wdata,
    input  logic             wake_done,
    output logic             arm,
    output logic [DLY_W-1:0] dly,
    output logic             vbus_ovr,
    output logic             vbus_force,
    output logic [31:0]      rdata
);
    // Hold the writable fields; reset to their documented defaults.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arm        <= 1'b0;
            dly        <= DLY_W'(DLY_RST);
            vbus_ovr   <= 1'b1;
            vbus_force <= 1'b0;
        end else if (wr_en) begin
            arm        <= wdata[BIT_ARM];
            dly        <= wdata[DLY_LSB +: DLY_W];
            vbus_ovr   <= wdata[BIT_VOVR];
            vbus_force <= wdata[BIT_VFORCE];
        end
    end

    // Assemble read data; every unlisted bit reads zero.
    always_comb begin
        rdata                    = '0;
        rdata[BIT_ARM]           = arm;
        rdata[BIT_DONE]          = wake_done;
        rdata[DLY_LSB +: DLY_W]  = dly;
        rdata[BIT_VFORCE]        = vbus_force;
        rdata[BIT_VOVR]          = vbus_ovr;
    end

    p_cfg_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (dly == $past(wdata[DLY_LSB +: DLY_W])) && (arm == $past(wdata[BIT_ARM])));
endmodule

// File: rtl/dsc_seq_fsm.sv
// Sleep/wake sequencer with a scaled settle counter.
// Assumes it runs on an ungated clock; clock enable is high only in
// RUN and AWAKE. Settle wait lasts dly << SCALE_SH cycles.
module dsc_seq_fsm
    import dsc_pkg::*;
#(
    parameter int unsigned DLY_W    = 12,
    parameter int unsigned SCALE_SH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic [DLY_W-1:0] dly,
    input  logic             pin_rise,
    input  logic             pin_fall,
    output logic             clk_en,
    output logic             wake_done
);
    localparam int unsigned CNT_W = DLY_W + SCALE_SH;

    dsc_state_e       state, state_nx;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_load;

    // Settle count minus one, since the first wait cycle counts.
    always_comb cnt_load = (CNT_W'(dly) << SCALE_SH) - CNT_W'(1);

    // Next-state decision for entry, settle, abort and release.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN:       if (arm && pin_fall) state_nx = ST_SLEEP;
            ST_SLEEP:     if (pin_rise) state_nx = (dly == '0) ? ST_AWAKE : ST_WAKE_WAIT;
            ST_WAKE_WAIT: if (pin_fall) state_nx = ST_SLEEP;
                          else if (cnt == '0) state_nx = ST_AWAKE;
            ST_AWAKE:     if (!arm) state_nx = ST_RUN;
            default:      state_nx = ST_RUN;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_nx;
    end

    // Settle counter: load on wake edge, count down while waiting.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  cnt <= '0;
        else if (state == ST_SLEEP && pin_rise)      cnt <= cnt_load;
        else if (state == ST_WAKE_WAIT && cnt != '0) cnt <= cnt - CNT_W'(1);
    end

    // Outputs decoded from state.
    always_comb begin
        clk_en    = (state == ST_RUN) || (state == ST_AWAKE);
        wake_done = (state == ST_AWAKE);
    end

    p_ignore_unarmed_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && !arm) |=> clk_en);
    p_sleep_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && arm && pin_fall) |=> (!clk_en && !wake_done));
    p_wait_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAKE_WAIT && cnt != '0 && !pin_fall) |=> (cnt == $past(cnt) - CNT_W'(1)) && !clk_en);
    p_zero_delay_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLEEP && pin_rise && dly == '0) |=> clk_en);
    p_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAKE_WAIT && pin_fall) |=> (state == ST_SLEEP));
    p_done_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_done && arm) |=> wake_done);
    p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_done && !arm) |=> (!wake_done && clk_en));
endmodule

// File: rtl/deep_sleep_ctrl.sv
// Top of the deep sleep sequencer: pin synchroniser, configuration
// register, sequencer and VBUS override mux.
// Assumes clk is the free-running oscillator clock, never gated.
module deep_sleep_ctrl #(
    parameter int unsigned DLY_W     = 12,
    parameter int unsigned DLY_RST   = 'h176,
    parameter int unsigned SCALE_SH  = 4,
    parameter int unsigned SYNC_STGS = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_wr,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    input  logic        wake_pin,
    input  logic        usb_vbus_req,
    output logic        usb_vbus_drv,
    output logic        sys_clk_en
);
    logic             pin_rise, pin_fall;
    logic             arm, vbus_ovr, vbus_force, wake_done;
    logic [DLY_W-1:0] dly;

    dsc_pin_sync #(.STAGES(SYNC_STGS)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_async(wake_pin),
        .pin_rise(pin_rise), .pin_fall(pin_fall)
    );

    dsc_cfg_regs #(.DLY_W(DLY_W), .DLY_RST(DLY_RST)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr), .wdata(cfg_wdata),
        .wake_done(wake_done), .arm(arm), .dly(dly),
        .vbus_ovr(vbus_ovr), .vbus_force(vbus_force), .rdata(cfg_rdata)
    );

    dsc_seq_fsm #(.DLY_W(DLY_W), .SCALE_SH(SCALE_SH)) u_fsm (
        .clk(clk), .rst_n(rst_n), .arm(arm), .dly(dly),
        .pin_rise(pin_rise), .pin_fall(pin_fall),
        .clk_en(sys_clk_en), .wake_done(wake_done)
    );

    // VBUS drive: software force value when override is on.
    always_comb usb_vbus_drv = vbus_ovr ? vbus_force : usb_vbus_req;
endmodule

// File: tb/deep_sleep_ctrl_bench.sv
module deep_sleep_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        wake_pin = 1'b1;
    logic        usb_vbus_req = 1'b0;
    logic        usb_vbus_drv;
    logic        sys_clk_en;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    deep_sleep_ctrl u_deep_sleep_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .wake_pin(wake_pin), .usb_vbus_req(usb_vbus_req),
        .usb_vbus_drv(usb_vbus_drv), .sys_clk_en(sys_clk_en)
    );

    always #10 clk = ~clk;

    function automatic logic [31:0] exp_rd(bit arm, bit dn, logic [11:0] d, bit frc, bit ovr);
        return {arm, dn, 14'b0, d, 1'b0, frc, ovr, 1'b0};
    endfunction

    function automatic logic [31:0] cfg_word(bit arm, logic [11:0] d, bit frc, bit ovr);
        return {arm, 15'b0, d, 1'b0, frc, ovr, 1'b0};
    endfunction

    function automatic int wake_edges(int d);
        return 3 + 16 * d;
    endfunction

    task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(logic [31:0] v);
        cfg_wr = 1'b1;
        cfg_wdata = v;
        @(posedge clk);
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    // Arm with delay d, sleep, wake; check every timing point.
    task automatic sleep_wake(logic [11:0] d, bit frc, bit ovr, string tag);
        wr(cfg_word(1'b1, d, frc, ovr));
        check(cfg_rdata == exp_rd(1, 0, d, frc, ovr), "R11", {tag, " readback"}, cfg_rdata, exp_rd(1, 0, d, frc, ovr));
        wake_pin = 1'b0;
        tick(2);
        check(sys_clk_en == 1'b1, "R3", {tag, " clk_en before entry edge"}, 32'(sys_clk_en), 32'd1);
        tick(1);
        check(sys_clk_en == 1'b0, "R3", {tag, " clk_en asleep"}, 32'(sys_clk_en), 32'd0);
        check(cfg_rdata[30] == 1'b0, "R3", {tag, " done flag asleep"}, 32'(cfg_rdata[30]), 32'd0);
        wake_pin = 1'b1;
        tick(wake_edges(int'(d)) - 1);
        check(sys_clk_en == 1'b0, (d == 0) ? "R5" : "R4", {tag, " clk_en one edge early"}, 32'(sys_clk_en), 32'd0);
        tick(1);
        check(sys_clk_en == 1'b1, (d == 0) ? "R5" : "R4", {tag, " clk_en at wake edge"}, 32'(sys_clk_en), 32'd1);
        check(cfg_rdata == exp_rd(1, 1, d, frc, ovr), "R7", {tag, " done flag set"}, cfg_rdata, exp_rd(1, 1, d, frc, ovr));
        wr(cfg_word(1'b0, d, frc, ovr));
        tick(1);
        check(cfg_rdata[30] == 1'b0 && sys_clk_en, "R8", {tag, " release"}, {cfg_rdata[30], 30'b0, sys_clk_en}, 32'd1);
    endtask

    initial begin
        int seed_v;
        seed_v = $urandom(32'd20240611);
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        check(cfg_rdata == 32'h0000_1762, "R1", "reset readback", cfg_rdata, 32'h0000_1762);
        check(sys_clk_en == 1'b1, "R1", "reset clk_en", 32'(sys_clk_en), 32'd1);
        usb_vbus_req = 1'b1; #1;
        check(usb_vbus_drv == 1'b0, "R9", "reset override forces 0", 32'(usb_vbus_drv), 32'd0);

        // R2: unarmed pin edges ignored
        wake_pin = 1'b0;
        tick(8);
        check(sys_clk_en == 1'b1, "R2", "unarmed fall ignored", 32'(sys_clk_en), 32'd1);
        wake_pin = 1'b1;
        tick(4);
        check(cfg_rdata[30] == 1'b0, "R2", "unarmed done flag", 32'(cfg_rdata[30]), 32'd0);

        // R10: reserved bits and done flag not writable
        wr(32'h7FFF_0009 | cfg_word(1'b0, 12'hABC, 1'b1, 1'b0));
        check(cfg_rdata == exp_rd(0, 0, 12'hABC, 1, 0), "R10", "reserved read zero", cfg_rdata, exp_rd(0, 0, 12'hABC, 1, 0));

        // R9 with override off: follow request
        usb_vbus_req = 1'b0; #1;
        check(usb_vbus_drv == 1'b0, "R9", "follow req 0", 32'(usb_vbus_drv), 32'd0);
        usb_vbus_req = 1'b1; #1;
        check(usb_vbus_drv == 1'b1, "R9", "follow req 1", 32'(usb_vbus_drv), 32'd1);
        @(negedge clk);

        // R5 directed zero delay
        sleep_wake(12'd0, 1'b0, 1'b1, "zero delay");

        // R7: pin edges while awake ignored, flag sticky
        wr(cfg_word(1'b1, 12'd1, 1'b0, 1'b1));
        wake_pin = 1'b0; tick(3);
        wake_pin = 1'b1; tick(wake_edges(1));
        check(cfg_rdata[30] == 1'b1, "R7", "awake before pin test", 32'(cfg_rdata[30]), 32'd1);
        wake_pin = 1'b0; tick(10);
        check(sys_clk_en && cfg_rdata[30], "R7", "fall while awake ignored", {cfg_rdata[30], 30'b0, sys_clk_en}, 32'h8000_0001);
        wake_pin = 1'b1; tick(10);
        check(sys_clk_en && cfg_rdata[30], "R7", "flag sticky after rise", {cfg_rdata[30], 30'b0, sys_clk_en}, 32'h8000_0001);
        wr(cfg_word(1'b0, 12'd1, 1'b0, 1'b1));
        tick(1);
        check(cfg_rdata[30] == 1'b0, "R8", "clear after sticky test", 32'(cfg_rdata[30]), 32'd0);

        // R6: abort during settle wait
        wr(cfg_word(1'b1, 12'd2, 1'b0, 1'b1));
        wake_pin = 1'b0; tick(3);
        wake_pin = 1'b1; tick(12);
        wake_pin = 1'b0; tick(3);
        tick(30);
        check(sys_clk_en == 1'b0, "R6", "aborted wait stays asleep", 32'(sys_clk_en), 32'd0);
        wake_pin = 1'b1;
        tick(wake_edges(2) - 1);
        check(sys_clk_en == 1'b0, "R6", "restarted wait not early", 32'(sys_clk_en), 32'd0);
        tick(1);
        check(sys_clk_en == 1'b1, "R6", "restarted wait completes", 32'(sys_clk_en), 32'd1);
        wr(cfg_word(1'b0, 12'd2, 1'b0, 1'b1));
        tick(1);

        // Random settle values and VBUS settings
        for (int i = 0; i < 10; i++) begin
            logic [11:0] d;
            bit frc, ovr, req;
            d   = 12'($urandom_range(1, 6));
            frc = 1'($urandom);
            ovr = 1'($urandom);
            req = 1'($urandom);
            sleep_wake(d, frc, ovr, "random");
            usb_vbus_req = req; #1;
            check(usb_vbus_drv == (ovr ? frc : req), "R9", "random vbus", 32'(usb_vbus_drv), 32'(ovr ? frc : req));
            @(negedge clk);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule